// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock. It contains the program counter, a 32 by 32-bit register file, an ALU, an instruction decoder, next-PC selection, a word-addressed instruction memory and a word-addressed data memory. Every instruction is one 32-bit word in one of three fixed formats:

- register form: `op[31:26] rs[25:21] rt[20:16] rd[15:11] shamt[10:6] funct[5:0]`
- immediate form: `op`, `rs`, `rt`, `imm[15:0]`
- jump form: `op`, `target[25:0]`

The core supports thirteen operations:

- register ALU: add, sub, and, or, slt
- immediate ALU: addi, ori, lui
- memory: lw, sw
- control flow: beq, bne, j

A full 32-bit constant is built with a lui followed by an ori. Branches are relative to the next PC. Jumps stay inside the current 256 MB region.

While `rst` is high, the environment writes programs and data into either memory through a side load port. It can read back any word of either memory through the same port. The port's read path is available at any time. The core retires one instruction on each rising edge while `rst` is low. Every store the core makes appears on a set of observation outputs in the cycle in which it is written.

Top module: `scp_core`

## Requirements
- R1: Reset is synchronous and active-high. A clock edge with `rst` high sets the PC to 0 and clears all 32 registers. While `rst` is high, the core writes neither registers nor data memory.
- R2: Opcode 0 selects the register form. The word 0x02324820 (rs=17, rt=18, rd=9, funct 0x20) writes r17+r18 into r9.
- R3: The register form with funct 0x20 / 0x22 / 0x24 / 0x25 computes rs+rt, rs-rt, rs AND rt and rs OR rt, and writes the result to rd.
- R4: The register form with funct 0x2A writes 1 to rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R5: addi (opcode 8) writes rs plus the sign-extended imm to rt.
- R6: lui (opcode 15) writes `{imm,16'h0}` to rt. ori (opcode 13) writes rs OR the zero-extended imm to rt. Together they build any 32-bit constant.
- R7: lw (opcode 35) and sw (opcode 43) use the byte address rs + sign-extended imm. The data memory word index is address[DAW+1:2]. During a sw, `st_en_o` is 1, `st_addr_o` carries the byte address and `st_data_o` carries rt.
- R8: beq (opcode 4) and bne (opcode 5) compare rs with rt. When taken, the next PC is PC+4+(sext(imm)<<2). When not taken, it is PC+4.
- R9: j (opcode 2) sets the next PC to `{(PC+4)[31:28], target, 2'b00}`.
- R10: r0 always reads 0, and writes to it are discarded.
- R11: Two kinds of word execute as no-ops, changing no register and no memory and advancing the PC by 4: any unlisted opcode, and a register-form word whose funct is not one of the five listed.
- R12: When `ld_en` is high, the load port writes `ld_wdata` into the data memory (`ld_dmem`=1) or the instruction memory (`ld_dmem`=0) at word `ld_addr`. `ld_rdata` always shows the addressed word of the selected memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port memory select: 1 data, 0 instruction |
| ld_addr | input | LAW (6) | Load-port word index |
| ld_wdata | input | 32 | Load-port write word |
| ld_rdata | output | 32 | Load-port read word of the selected memory |
| pc_o | output | 32 | Current program counter |
| st_en_o | output | 1 | Core store in progress this cycle |
| st_addr_o | output | 32 | Byte address of the core store |
| st_data_o | output | 32 | Data of the core store |

## Verification
Two functions often meet in the same cycle:

- **Writing a register and reading it.** An instruction writes a register at the clock edge, and the very next instruction reads that register combinationally.
- **Comparing and redirecting.** A branch compares a value that was produced one cycle earlier, and in the same cycle it decides the next PC.

Directed programs provoke both cases on purpose. They chain dependent ALU operations back to back, run a branch directly after the instruction that produced its operand, and run a countdown loop whose exit branch tests a register decremented two instructions before. Each case is judged only through the final data memory contents, read back through the load port, and through the PC and store outputs, against values worked out by hand from the requirements.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_J    = 6'd2;
    localparam logic [5:0] OPC_BEQ  = 6'd4;
    localparam logic [5:0] OPC_BNE  = 6'd5;
    localparam logic [5:0] OPC_ADDI = 6'd8;
    localparam logic [5:0] OPC_ORI  = 6'd13;
    localparam logic [5:0] OPC_LUI  = 6'd15;
    localparam logic [5:0] OPC_LW   = 6'd35;
    localparam logic [5:0] OPC_SW   = 6'd43;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SEXT, IMM_ZEXT, IMM_UPPER
    } imm_kind_e;

    typedef struct packed {
        logic      reg_we;
        logic      dst_rd;
        logic      use_imm;
        imm_kind_e imm_kind;
        alu_op_e   alu_op;
        logic      mem_rd;
        logic      mem_wr;
        logic      br_eq;
        logic      br_ne;
        logic      jump;
    } ctrl_t;

endpackage

// File: rtl/scp_alu.sv
module scp_alu
    import scp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] y_o,
    output logic         zero_o
);
    logic [W-1:0] diff;

    always_comb begin
        diff = a_i - b_i;
        unique case (op_i)
            ALU_ADD:   y_o = a_i + b_i;
            ALU_SUB:   y_o = diff;
            ALU_AND:   y_o = a_i & b_i;
            ALU_OR:    y_o = a_i | b_i;
            ALU_SLT:   y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            ALU_PASSB: y_o = b_i;
            default:   y_o = '0;
        endcase
        zero_o = (diff == '0);
    end
endmodule

// File: rtl/scp_decode.sv
module scp_decode
    import scp_pkg::*;
(
    input  logic [31:0] instr_i,
    output ctrl_t       ctrl_o,
    output logic [4:0]  rs_o,
    output logic [4:0]  rt_o,
    output logic [4:0]  rd_o,
    output logic [15:0] imm_o,
    output logic [25:0] tgt_o
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic [4:0] unused_shamt;

    assign opc          = instr_i[31:26];
    assign fn           = instr_i[5:0];
    assign rs_o         = instr_i[25:21];
    assign rt_o         = instr_i[20:16];
    assign rd_o         = instr_i[15:11];
    assign unused_shamt = instr_i[10:6];
    assign imm_o        = instr_i[15:0];
    assign tgt_o        = instr_i[25:0];

    always_comb begin
        ctrl_o = '0;
        case (opc)
            OPC_REG: begin
                ctrl_o.dst_rd = 1'b1;
                ctrl_o.reg_we = 1'b1;
                case (fn)
                    FN_ADD:  ctrl_o.alu_op = ALU_ADD;
                    FN_SUB:  ctrl_o.alu_op = ALU_SUB;
                    FN_AND:  ctrl_o.alu_op = ALU_AND;
                    FN_OR:   ctrl_o.alu_op = ALU_OR;
                    FN_SLT:  ctrl_o.alu_op = ALU_SLT;
                    default: ctrl_o = '0;
                endcase
            end
            OPC_ADDI: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.use_imm = 1'b1;
            end
            OPC_ORI: begin
                ctrl_o.reg_we   = 1'b1;
                ctrl_o.use_imm  = 1'b1;
                ctrl_o.imm_kind = IMM_ZEXT;
                ctrl_o.alu_op   = ALU_OR;
            end
            OPC_LUI: begin
                ctrl_o.reg_we   = 1'b1;
                ctrl_o.use_imm  = 1'b1;
                ctrl_o.imm_kind = IMM_UPPER;
                ctrl_o.alu_op   = ALU_PASSB;
            end
            OPC_LW: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.use_imm = 1'b1;
                ctrl_o.mem_rd  = 1'b1;
            end
            OPC_SW: begin
                ctrl_o.use_imm = 1'b1;
                ctrl_o.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl_o.alu_op = ALU_SUB;
                ctrl_o.br_eq  = 1'b1;
            end
            OPC_BNE: begin
                ctrl_o.alu_op = ALU_SUB;
                ctrl_o.br_ne  = 1'b1;
            end
            OPC_J:   ctrl_o.jump = 1'b1;
            default: ctrl_o = '0;
        endcase
    end
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [RAW-1:0] ra1_i,
    input  logic [RAW-1:0] ra2_i,
    output logic [W-1:0]   rd1_o,
    output logic [W-1:0]   rd2_o,
    input  logic           we_i,
    input  logic [RAW-1:0] wa_i,
    input  logic [W-1:0]   wd_i
);
    logic [W-1:0] regs_d [NREG];
    logic [W-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we_i && wa_i != '0) regs_d[wa_i] = wd_i;
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '{default: '0};
        else     regs_q <= regs_d;
    end

    assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
    assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];

    // R10
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && wa_i == '0) |=> (regs_q[0] == '0));
endmodule

// File: rtl/scp_wmem.sv
module scp_wmem #(
    parameter int WORDS = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [W-1:0]  wd_i,
    input  logic [AW-1:0] raa_i,
    output logic [W-1:0]  rda_o,
    input  logic [AW-1:0] rab_i,
    output logic [W-1:0]  rdb_o
);
    logic [W-1:0] mem_d [WORDS];
    logic [W-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[wa_i] = wd_i;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rda_o = mem_q[raa_i];
    assign rdb_o = mem_q[rab_i];
endmodule

// File: rtl/scp_core.sv
module scp_core
    import scp_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic            ld_dmem,
    input  logic [LAW-1:0]  ld_addr,
    input  logic [31:0]     ld_wdata,
    output logic [31:0]     ld_rdata,
    output logic [31:0]     pc_o,
    output logic            st_en_o,
    output logic [31:0]     st_addr_o,
    output logic [31:0]     st_data_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [31:0]     instr;
    ctrl_t           ctrl;
    logic [4:0]      rs_a, rt_a, rd_a, wr_a;
    logic [15:0]     imm16;
    logic [25:0]     tgt26;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, imm_sext, alu_b, alu_y, wb_val;
    logic [XLEN-1:0] dm_rdata, im_ld_rdata, dm_ld_rdata, pc4, br_tgt, j_tgt;
    logic            alu_zero, br_taken, rf_we;
    logic            dm_we, im_we;
    logic [DAW-1:0]  dm_wa;
    logic [XLEN-1:0] dm_wd;
    logic            unused_bits;

    scp_wmem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
        .clk   (clk),
        .we_i  (im_we),
        .wa_i  (ld_addr[IAW-1:0]),
        .wd_i  (ld_wdata),
        .raa_i (st_q.pc[IAW+1:2]),
        .rda_o (instr),
        .rab_i (ld_addr[IAW-1:0]),
        .rdb_o (im_ld_rdata)
    );

    scp_decode u_dec (
        .instr_i (instr),
        .ctrl_o  (ctrl),
        .rs_o    (rs_a),
        .rt_o    (rt_a),
        .rd_o    (rd_a),
        .imm_o   (imm16),
        .tgt_o   (tgt26)
    );

    scp_regfile #(.NREG(32), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .ra1_i (rs_a),
        .ra2_i (rt_a),
        .rd1_o (rs_val),
        .rd2_o (rt_val),
        .we_i  (rf_we),
        .wa_i  (wr_a),
        .wd_i  (wb_val)
    );

    always_comb begin
        imm_sext = {{16{imm16[15]}}, imm16};
        case (ctrl.imm_kind)
            IMM_ZEXT:  imm_ext = {16'h0, imm16};
            IMM_UPPER: imm_ext = {imm16, 16'h0};
            default:   imm_ext = imm_sext;
        endcase
        alu_b = ctrl.use_imm ? imm_ext : rt_val;
    end

    scp_alu #(.W(XLEN)) u_alu (
        .a_i    (rs_val),
        .b_i    (alu_b),
        .op_i   (ctrl.alu_op),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    scp_wmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk   (clk),
        .we_i  (dm_we),
        .wa_i  (dm_wa),
        .wd_i  (dm_wd),
        .raa_i (alu_y[DAW+1:2]),
        .rda_o (dm_rdata),
        .rab_i (ld_addr[DAW-1:0]),
        .rdb_o (dm_ld_rdata)
    );

    always_comb begin
        wb_val = ctrl.mem_rd ? dm_rdata : alu_y;
        wr_a   = ctrl.dst_rd ? rd_a : rt_a;
        rf_we  = ctrl.reg_we && !rst;

        im_we  = ld_en && !ld_dmem;
        if (ld_en && ld_dmem) begin
            dm_we = 1'b1;
            dm_wa = ld_addr[DAW-1:0];
            dm_wd = ld_wdata;
        end else begin
            dm_we = ctrl.mem_wr && !rst;
            dm_wa = alu_y[DAW+1:2];
            dm_wd = rt_val;
        end
    end

    always_comb begin
        pc4      = st_q.pc + 32'd4;
        br_tgt   = pc4 + {imm_sext[XLEN-3:0], 2'b00};
        j_tgt    = {pc4[31:28], tgt26, 2'b00};
        br_taken = (ctrl.br_eq && alu_zero) || (ctrl.br_ne && !alu_zero);
        st_d     = st_q;
        if (rst)            st_d.pc = '0;
        else if (ctrl.jump) st_d.pc = j_tgt;
        else if (br_taken)  st_d.pc = br_tgt;
        else                st_d.pc = pc4;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ld_rdata  = ld_dmem ? dm_ld_rdata : im_ld_rdata;
    assign pc_o      = st_q.pc;
    assign st_en_o   = ctrl.mem_wr && !rst;
    assign st_addr_o = alu_y;
    assign st_data_o = rt_val;

    assign unused_bits = ^{alu_y[1:0], alu_y[XLEN-1:DAW+2]};

    // R8
    br_target_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctrl.br_eq || ctrl.br_ne) && (rs_val == rt_val) == ctrl.br_eq)
        |=> (st_q.pc == $past(st_q.pc) + 32'd4 + {$past(imm_sext[XLEN-3:0]), 2'b00}));

    // R9
    jump_region_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> (st_q.pc[27:0] == {$past(instr[25:0]), 2'b00}));

    // R11
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.jump && !ctrl.br_eq && !ctrl.br_ne) |=> (st_q.pc == $past(st_q.pc) + 32'd4));

    // R6
    lui_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_LUI && rf_we) |-> (wb_val[15:0] == 16'h0));

    // R1
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.pc[1:0] == 2'b00);
endmodule

// File: tb/sim_scp_core.sv
`timescale 1ns/1ps
module sim_scp_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_wdata = '0;
    logic [31:0] ld_rdata, pc_o, st_addr_o, st_data_o;
    logic        st_en_o;
    int          n_run = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    scp_core u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
        .ld_wdata(ld_wdata), .ld_rdata(ld_rdata), .pc_o(pc_o), .st_en_o(st_en_o),
        .st_addr_o(st_addr_o), .st_data_o(st_data_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(int word);
        return {6'd2, 26'(word)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(bit dm, int addr, logic [31:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_dmem = dm; ld_addr = 6'(addr); ld_wdata = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic get(bit dm, int addr, output logic [31:0] w);
        @(negedge clk);
        ld_dmem = dm; ld_addr = 6'(addr);
        #1 w = ld_rdata;
    endtask

    task automatic halt_core();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    // R1 R2 R3 R4 R5 R10 R12
    task automatic t_alu();
        logic [31:0] w;
        rst = 1'b1;
        put(0, 0, enc_i(6'd8, 0, 17, 16'd100));
        put(0, 1, enc_i(6'd8, 0, 18, 16'hFFF9));
        put(0, 2, 32'h02324820);
        put(0, 3, enc_r(17, 18, 10, 6'h22));
        put(0, 4, enc_r(17, 18, 11, 6'h24));
        put(0, 5, enc_r(17, 18, 12, 6'h25));
        put(0, 6, enc_r(18, 17, 13, 6'h2A));
        put(0, 7, enc_r(17, 18, 14, 6'h2A));
        put(0, 8, enc_i(6'd8, 0, 0, 16'd55));
        put(0, 9,  enc_i(6'd43, 0, 9, 16'd0));
        put(0, 10, enc_i(6'd43, 0, 10, 16'd4));
        put(0, 11, enc_i(6'd43, 0, 11, 16'd8));
        put(0, 12, enc_i(6'd43, 0, 12, 16'd12));
        put(0, 13, enc_i(6'd43, 0, 13, 16'd16));
        put(0, 14, enc_i(6'd43, 0, 14, 16'd20));
        put(0, 15, enc_i(6'd43, 0, 0, 16'd24));
        put(0, 16, enc_j(16));
        put(1, 6, 32'hDEADBEEF);
        get(0, 2, w);  check("R12 imem readback", w, 32'h02324820);
        get(1, 6, w);  check("R12 dmem readback", w, 32'hDEADBEEF);
        check("R1 pc in reset", pc_o, 32'd0);
        rst = 1'b0;
        @(negedge clk); check("R1 pc after first step", pc_o, 32'd4);
        @(negedge clk); check("R1 pc after second step", pc_o, 32'd8);
        repeat (30) @(negedge clk);
        halt_core();
        check("R1 pc returns to 0", pc_o, 32'd0);
        get(1, 0, w); check("R2 add encoded word", w, 32'd93);
        get(1, 1, w); check("R3 sub", w, 32'd107);
        get(1, 2, w); check("R3 and", w, 32'h00000060);
        get(1, 3, w); check("R3 or", w, 32'hFFFFFFFD);
        get(1, 4, w); check("R4 slt neg<pos", w, 32'd1);
        get(1, 5, w); check("R4 slt pos<neg", w, 32'd0);
        get(1, 6, w); check("R10 r0 write discarded", w, 32'd0);
    endtask

    // R6 R7
    task automatic t_mem();
        logic [31:0] w;
        rst = 1'b1;
        put(0, 0, enc_i(6'd15, 0, 1, 16'h1234));
        put(0, 1, enc_i(6'd13, 1, 1, 16'hABCD));
        put(0, 2, enc_i(6'd13, 0, 2, 16'h8000));
        put(0, 3, enc_i(6'd8, 0, 3, 16'd40));
        put(0, 4, enc_i(6'd35, 3, 4, 16'hFFF8));
        put(0, 5, enc_i(6'd43, 3, 1, 16'd4));
        put(0, 6, enc_i(6'd43, 3, 2, 16'd8));
        put(0, 7, enc_i(6'd43, 3, 4, 16'hFFD8));
        put(0, 8, enc_j(8));
        put(1, 8, 32'h55AA00FF);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R7 store strobe", {31'd0, st_en_o}, 32'd1);
        check("R7 store address", st_addr_o, 32'd44);
        check("R6 lui/ori constant on store data", st_data_o, 32'h1234ABCD);
        repeat (10) @(negedge clk);
        halt_core();
        get(1, 11, w); check("R6 lui+ori", w, 32'h1234ABCD);
        get(1, 12, w); check("R6 ori zero-extends", w, 32'h00008000);
        get(1, 0, w);  check("R7 lw neg disp then sw", w, 32'h55AA00FF);
    endtask

    // R8 R1
    task automatic t_branch();
        logic [31:0] w;
        rst = 1'b1;
        put(0, 0,  enc_i(6'd8, 0, 1, 16'd5));
        put(0, 1,  enc_i(6'd8, 0, 2, 16'd5));
        put(0, 2,  enc_i(6'd4, 1, 2, 16'd2));
        put(0, 3,  enc_i(6'd8, 0, 5, 16'd1));
        put(0, 4,  enc_i(6'd8, 0, 5, 16'd2));
        put(0, 5,  enc_i(6'd5, 1, 2, 16'd1));
        put(0, 6,  enc_i(6'd8, 0, 6, 16'd7));
        put(0, 7,  enc_i(6'd5, 6, 1, 16'd2));
        put(0, 8,  enc_i(6'd8, 0, 6, 16'd99));
        put(0, 9,  enc_j(9));
        put(0, 10, enc_i(6'd4, 1, 6, 16'd3));
        put(0, 11, enc_i(6'd8, 0, 7, 16'd3));
        put(0, 12, enc_i(6'd8, 7, 7, 16'hFFFF));
        put(0, 13, enc_i(6'd8, 9, 9, 16'd1));
        put(0, 14, enc_i(6'd5, 7, 0, 16'hFFFD));
        put(0, 15, enc_i(6'd43, 0, 5, 16'd0));
        put(0, 16, enc_i(6'd43, 0, 6, 16'd4));
        put(0, 17, enc_i(6'd43, 0, 9, 16'd8));
        put(0, 18, enc_j(18));
        put(1, 0, 32'hFFFFFFFF);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 beq taken target", pc_o, 32'd20);
        repeat (40) @(negedge clk);
        halt_core();
        get(1, 0, w); check("R8 beq skipped both (r5 from reset R1)", w, 32'd0);
        get(1, 1, w); check("R8 bne taken skipped overwrite", w, 32'd7);
        get(1, 2, w); check("R8 backward bne loop count", w, 32'd3);
    endtask

    // R9 R11
    task automatic t_jump();
        logic [31:0] w;
        rst = 1'b1;
        put(0, 0, enc_j(3));
        put(0, 1, enc_i(6'd8, 0, 1, 16'd11));
        put(0, 2, enc_i(6'd43, 0, 1, 16'd12));
        put(0, 3, enc_i(6'h3F, 0, 2, 16'h1234));
        put(0, 4, enc_r(1, 1, 3, 6'h00));
        put(0, 5, enc_i(6'd8, 0, 4, 16'd9));
        put(0, 6, enc_i(6'd43, 0, 2, 16'd0));
        put(0, 7, enc_i(6'd43, 0, 3, 16'd4));
        put(0, 8, enc_i(6'd43, 0, 4, 16'd8));
        put(0, 9, enc_i(6'd43, 0, 1, 16'd12));
        put(0, 10, enc_j(10));
        for (int i = 0; i < 4; i++) put(1, i, 32'hA5A5A5A5);
        rst = 1'b0;
        @(negedge clk); check("R9 jump target", pc_o, 32'd12);
        @(negedge clk); check("R11 unknown opcode advances pc", pc_o, 32'd16);
        repeat (20) @(negedge clk);
        check("R9 jump to self holds pc", pc_o, 32'd40);
        halt_core();
        get(1, 0, w); check("R11 unknown opcode no write", w, 32'd0);
        get(1, 1, w); check("R11 unknown funct no write", w, 32'd0);
        get(1, 2, w); check("R9 execution resumed at target", w, 32'd9);
        get(1, 3, w); check("R9 skipped instruction", w, 32'd0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_alu();
        t_mem();
        t_branch();
        t_jump();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule